// File: doc/BRIEF.md
# Shared Two-Port Crossbar Link Arbiter

This block is one arbiter that serves two destination (FIFO-side) ports of an application-specific crossbar. The crossbar has links only where the application needs them. The links that end on either of the two served ports form one merged list, which is fixed when the block is built. A single round-robin pointer walks that list one entry per cycle. Pairing ports this way halves the number of arbiters the crossbar needs. The cost is that a request may wait while the pointer passes over the other port's links. Several copies run side by side in a crossbar, one for each pair of ports. A build that holds every link in one list behaves as a fully sequential scheduler.

Every processor presents three things: a valid flag, a release flag and a target-port field. When the pointer sits on an entry, the arbiter looks at the entry's source processor. It decodes that processor's target-port field against the identifier of the entry's destination port. The entry wins the port only if that port is idle. Setting up a link takes a two-step handshake. In the first step the arbiter drives a grant towards the processor. In the second step it commits the link, but only when the addressed FIFO holds data. Each served port holds at most one link at a time, so at most two links are open together.

Top module: `shared_pair_arbiter`

## Requirements
- R1: After a synchronous reset, `hs_grant`, `accept` and `port_busy` are all zero, and the pointer starts at entry 0 of the merged list.
- R2: An entry with no qualifying request moves the pointer to the next entry on the next clock. After the last entry the pointer wraps to entry 0. The merged list stores entry i's source in bits [i*SRC_W +: SRC_W] of `LINK_SRC` and its port select in bit i of `LINK_DST` (0 = port A, 1 = port B).
- R3: The pointer may sit on entry k while its source has `req_valid` set, that source's target field equals the entry port's identifier (`PORT_A_ID` or `PORT_B_ID`), and that port is idle. In that case `hs_grant` becomes one-hot on the source in the next cycle, and it stays high for exactly one cycle.
- R4: A valid request whose target field does not equal the identifier of the entry's port produces no grant, and the pointer moves on.
- R5: In the cycle that follows a grant, a non-empty addressed FIFO (`fifo_empty` low) opens the link. On the next edge the port's `port_busy` bit rises, `port_src` holds the source, `accept` pulses for one cycle on that port's bit, and the pointer moves past the entry.
- R6: If the addressed FIFO is empty in the cycle after a grant, no link opens. The pointer stays on the same entry and scanning resumes from there.
- R7: An entry whose port is busy is skipped, even when its source has a valid request.
- R8: A port is released when the pointer reaches the entry that holds that port's link and the entry's source has `req_clear` set with a matching target field. On the next edge `port_busy` for that port falls. Release takes priority over a new request.
- R9: The two ports' busy state and link source are tracked independently, and both ports may hold a link at the same time.
- R10: At most one bit of `hs_grant` is high in any cycle, and no new grant is issued in the cycle after a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PROC | Per-processor link request |
| req_clear | input | NUM_PROC | Per-processor link release request |
| req_port | input | NUM_PROC*PORT_W | Per-processor target port field, processor i at [i*PORT_W +: PORT_W] |
| fifo_empty | input | 2 | Empty flag of the addressed FIFO on port A (bit 0) and port B (bit 1) |
| hs_grant | output | NUM_PROC | One-hot handshake grant to the selected processor |
| accept | output | 2 | One-cycle pulse when a link opens on port A or B |
| port_busy | output | 2 | Port A/B holds an open link |
| port_src | output | 2*SRC_W | Source processor of the open link, port A at [SRC_W-1:0] |

## Verification
The hardest state to reach is a release at the exact moment a port is held. The pointer must sit on the holding entry while the holding processor asserts release with a matching target, and at the same time a second processor may be asking for the freed port. Directed phases build this state on purpose. One processor takes port A. A second processor then requests port A and is skipped while A is held. The first processor then releases A, and the bench checks that the release happens before any new grant. Long random runs follow, with a low release rate, mismatching target fields and randomly empty FIFOs. A cycle-level bench model computes the grant, accept and busy outputs from the rules, and every cycle is compared against it.

// File: rtl/shared_arb_pkg.sv
package shared_arb_pkg;
  typedef enum logic {PH_SCAN = 1'b0, PH_ACK = 1'b1} arb_phase_t;

  localparam int NUM_SERVED = 2;
endpackage

// File: rtl/sarb_entry_decode.sv
module sarb_entry_decode #(
  parameter int NUM_PROC  = 6,
  parameter int NUM_LINKS = 6,
  parameter int PORT_W    = 3,
  parameter int SRC_W     = 3,
  parameter int LINK_W    = 3,
  parameter logic [NUM_LINKS*SRC_W-1:0] LINK_SRC = '0,
  parameter logic [NUM_LINKS-1:0]       LINK_DST = '0,
  parameter logic [PORT_W-1:0] PORT_A_ID = '0,
  parameter logic [PORT_W-1:0] PORT_B_ID = '0
) (
  input  logic [LINK_W-1:0]          ptr,
  input  logic [NUM_PROC-1:0]        req_valid,
  input  logic [NUM_PROC-1:0]        req_clear,
  input  logic [NUM_PROC*PORT_W-1:0] req_port,
  output logic [SRC_W-1:0]           ent_src,
  output logic                       ent_dst,
  output logic                       ent_req,
  output logic                       ent_clr
);
  logic [SRC_W-1:0] src_tab [NUM_LINKS];
  logic             dst_tab [NUM_LINKS];
  logic             hit_tab [NUM_LINKS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINKS; gi++) begin : g_ent
      assign src_tab[gi] = LINK_SRC[gi*SRC_W +: SRC_W];
      assign dst_tab[gi] = LINK_DST[gi];
      assign hit_tab[gi] = (req_port[int'(LINK_SRC[gi*SRC_W +: SRC_W])*PORT_W +: PORT_W]
                            == (LINK_DST[gi] ? PORT_B_ID : PORT_A_ID));
    end
  endgenerate

  logic tgt_hit;
  always_comb begin
    ent_src = src_tab[0];
    ent_dst = dst_tab[0];
    tgt_hit = hit_tab[0];
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (ptr == LINK_W'(i)) begin
        ent_src = src_tab[i];
        ent_dst = dst_tab[i];
        tgt_hit = hit_tab[i];
      end
    end
    ent_req = req_valid[ent_src] && tgt_hit;
    ent_clr = req_clear[ent_src] && tgt_hit;
  end
endmodule

// File: rtl/sarb_pointer.sv
module sarb_pointer #(
  parameter int NUM_LINKS = 6,
  parameter int LINK_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [LINK_W-1:0] ptr
);
  localparam logic [LINK_W-1:0] LAST = LINK_W'(NUM_LINKS - 1);

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
  assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (advance && ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/sarb_port_track.sv
module sarb_port_track #(
  parameter int SRC_W  = 3,
  parameter int LINK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_link,
  input  logic              close_link,
  input  logic [SRC_W-1:0]  open_src,
  input  logic [LINK_W-1:0] open_idx,
  output logic              busy,
  output logic [SRC_W-1:0]  src,
  output logic [LINK_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      src  <= '0;
      idx  <= '0;
    end else if (open_link) begin
      busy <= 1'b1;
      src  <= open_src;
      idx  <= open_idx;
    end else if (close_link) begin
      busy <= 1'b0;
    end
  end

  assert_no_double_open_R9: assert property (@(posedge clk) disable iff (rst)
    open_link |-> !busy);
  assert_release_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(close_link));
  assert_src_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !open_link) |=> $stable(src));
endmodule

// File: rtl/shared_pair_arbiter.sv
module shared_pair_arbiter
  import shared_arb_pkg::*;
#(
  parameter int NUM_PROC  = 6,
  parameter int NUM_LINKS = 6,
  parameter int PORT_W    = 3,
  parameter int SRC_W     = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  parameter logic [NUM_LINKS*SRC_W-1:0] LINK_SRC = 18'o054321,
  parameter logic [NUM_LINKS-1:0]       LINK_DST = 6'b100000,
  parameter logic [PORT_W-1:0] PORT_A_ID = 3'd0,
  parameter logic [PORT_W-1:0] PORT_B_ID = 3'd1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PROC-1:0]         req_valid,
  input  logic [NUM_PROC-1:0]         req_clear,
  input  logic [NUM_PROC*PORT_W-1:0]  req_port,
  input  logic [NUM_SERVED-1:0]       fifo_empty,
  output logic [NUM_PROC-1:0]         hs_grant,
  output logic [NUM_SERVED-1:0]       accept,
  output logic [NUM_SERVED-1:0]       port_busy,
  output logic [NUM_SERVED*SRC_W-1:0] port_src
);
  localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;

  arb_phase_t       phase;
  logic [LINK_W-1:0] ptr;
  logic [SRC_W-1:0]  ent_src;
  logic              ent_dst, ent_req, ent_clr;
  logic [LINK_W-1:0] link_idx [NUM_SERVED];
  logic              do_clear, do_grant, do_accept, advance;

  sarb_entry_decode #(
    .NUM_PROC(NUM_PROC), .NUM_LINKS(NUM_LINKS), .PORT_W(PORT_W),
    .SRC_W(SRC_W), .LINK_W(LINK_W), .LINK_SRC(LINK_SRC), .LINK_DST(LINK_DST),
    .PORT_A_ID(PORT_A_ID), .PORT_B_ID(PORT_B_ID)
  ) u_dec (
    .ptr(ptr), .req_valid(req_valid), .req_clear(req_clear), .req_port(req_port),
    .ent_src(ent_src), .ent_dst(ent_dst), .ent_req(ent_req), .ent_clr(ent_clr)
  );

  sarb_pointer #(.NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W)) u_ptr (
    .clk(clk), .rst(rst), .advance(advance), .ptr(ptr)
  );

  genvar gp;
  generate
    for (gp = 0; gp < NUM_SERVED; gp++) begin : g_port
      sarb_port_track #(.SRC_W(SRC_W), .LINK_W(LINK_W)) u_trk (
        .clk(clk), .rst(rst),
        .open_link(do_accept && (ent_dst == gp[0])),
        .close_link(do_clear && (ent_dst == gp[0])),
        .open_src(ent_src), .open_idx(ptr),
        .busy(port_busy[gp]), .src(port_src[gp*SRC_W +: SRC_W]),
        .idx(link_idx[gp])
      );
    end
  endgenerate

  always_comb begin
    do_clear  = 1'b0;
    do_grant  = 1'b0;
    do_accept = 1'b0;
    advance   = 1'b0;
    if (phase == PH_SCAN) begin
      do_clear = ent_clr && port_busy[ent_dst] && (link_idx[ent_dst] == ptr);
      do_grant = !do_clear && ent_req && !port_busy[ent_dst];
      advance  = !do_grant;
    end else begin
      do_accept = !fifo_empty[ent_dst];
      advance   = do_accept;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_SCAN;
      hs_grant <= '0;
      accept   <= '0;
    end else begin
      phase    <= do_grant ? PH_ACK : PH_SCAN;
      hs_grant <= do_grant ? (NUM_PROC'(1) << ent_src) : '0;
      accept   <= do_accept ? (NUM_SERVED'(1) << ent_dst) : '0;
    end
  end

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hs_grant));
  assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (rst)
    (hs_grant != '0) |=> (hs_grant == '0));
  assert_grant_idle_port_R3: assert property (@(posedge clk) disable iff (rst)
    (hs_grant != '0) |-> !port_busy[ent_dst]);
  assert_accept_after_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (accept != '0) |-> $past(hs_grant != '0));
  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(port_busy[0]) |-> accept[0]);
  assert_empty_holds_ptr_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACK && fifo_empty[ent_dst]) |=> ($stable(ptr) && accept == '0));
endmodule

// File: tb/tb_shared_pair_arbiter.sv
`timescale 1ns/1ps
module tb_shared_pair_arbiter;
  localparam int NP = 6, NL = 6, PW = 3, SW = 3;
  localparam logic [NL*SW-1:0] LSRC = 18'o054321;
  localparam logic [NL-1:0]    LDST = 6'b100000;

  logic clk = 0, rst = 1;
  logic [NP-1:0] req_valid = '0, req_clear = '0;
  logic [NP*PW-1:0] req_port = '0;
  logic [1:0] fifo_empty = '0;
  logic [NP-1:0] hs_grant;
  logic [1:0] accept, port_busy;
  logic [2*SW-1:0] port_src;

  int checks = 0, failures = 0;
  bit finished = 0;

  // bench model state
  int m_ptr, m_ack;
  int m_busy [2], m_src [2], m_link [2];
  logic [NP-1:0] m_grant;
  logic [1:0] m_acc;

  shared_pair_arbiter #(.NUM_PROC(NP), .NUM_LINKS(NL), .PORT_W(PW), .SRC_W(SW),
    .LINK_SRC(LSRC), .LINK_DST(LDST), .PORT_A_ID(3'd0), .PORT_B_ID(3'd1)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_clear(req_clear),
    .req_port(req_port), .fifo_empty(fifo_empty), .hs_grant(hs_grant),
    .accept(accept), .port_busy(port_busy), .port_src(port_src));

  always #5 clk = ~clk;

  function automatic int ent_src(int k); return int'(LSRC[k*SW +: SW]); endfunction
  function automatic int ent_dst(int k); return int'(LDST[k]); endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    int s, d; bit match;
    m_grant = '0; m_acc = '0;
    if (rst) begin
      m_ptr = 0; m_ack = 0;
      for (int p = 0; p < 2; p++) begin m_busy[p] = 0; m_src[p] = 0; m_link[p] = 0; end
      return;
    end
    s = ent_src(m_ptr); d = ent_dst(m_ptr);
    match = (int'(req_port[s*PW +: PW]) == d);
    if (m_ack) begin
      m_ack = 0;
      if (!fifo_empty[d]) begin
        m_busy[d] = 1; m_src[d] = s; m_link[d] = m_ptr; m_acc[d] = 1'b1;
        m_ptr = (m_ptr + 1) % NL;
      end
    end else if (req_clear[s] && match && m_busy[d] && m_link[d] == m_ptr) begin
      m_busy[d] = 0; m_ptr = (m_ptr + 1) % NL;
    end else if (req_valid[s] && match && !m_busy[d]) begin
      m_ack = 1; m_grant[s] = 1'b1;
    end else begin
      m_ptr = (m_ptr + 1) % NL;
    end
  endtask

  // one clock: DUT sees current inputs at posedge; compare at the following negedge
  task automatic tick();
    @(negedge clk);
    model_step();
    check("R3 grant", int'(hs_grant), int'(m_grant));
    check("R5 accept", int'(accept), int'(m_acc));
    check("R9 busy", int'(port_busy), m_busy[1]*2 + m_busy[0]);
    if (m_busy[0]) check("R9 srcA", int'(port_src[SW-1:0]), m_src[0]);
    if (m_busy[1]) check("R9 srcB", int'(port_src[2*SW-1:SW]), m_src[1]);
  endtask

  task automatic set_req(int p, bit v, bit c, int tgt);
    req_valid[p] = v; req_clear[p] = c; req_port[p*PW +: PW] = PW'(tgt);
  endtask

  task automatic do_reset();
    rst = 1; req_valid = '0; req_clear = '0; req_port = '0; fifo_empty = '0;
    tick(); tick();
    rst = 0;
  endtask

  initial begin
    int n; bit seen; int unused_seed;
    unused_seed = $urandom(32'd1234);
    do_reset();
    // R1 reset state
    check("R1 grant", int'(hs_grant), 0);
    check("R1 busy", int'(port_busy), 0);
    check("R1 accept", int'(accept), 0);

    // R2/R3: processor 3 is entry 2, port A; pointer starts at 0 -> grant on 3rd clock
    set_req(3, 1, 0, 0);
    n = 0; seen = 0;
    while (!seen && n < 20) begin tick(); n++; if (hs_grant != '0) seen = 1; end
    check("R2 clocks to first grant", n, 3);
    check("R3 grant onehot", int'(hs_grant), 1 << 3);
    tick();
    check("R5 busy A", int'(port_busy), 1);
    check("R5 srcA", int'(port_src[SW-1:0]), 3);
    check("R5 accept pulse", int'(accept), 1);
    set_req(3, 0, 0, 0);

    // R7: processor 2 asks for busy port A; skipped for several laps
    set_req(2, 1, 0, 0);
    seen = 0;
    for (int i = 0; i < 14; i++) begin tick(); if (hs_grant != '0) seen = 1; end
    check("R7 no grant on busy port", int'(seen), 0);
    set_req(2, 0, 0, 0);

    // R9: processor 0 takes port B while A is held
    set_req(0, 1, 0, 1);
    for (int i = 0; i < 10; i++) tick();
    check("R9 both busy", int'(port_busy), 3);
    check("R9 srcB", int'(port_src[2*SW-1:SW]), 0);
    set_req(0, 0, 0, 1);

    // R8: processor 3 releases A while processor 2 waits for A
    set_req(3, 0, 1, 0);
    set_req(2, 1, 0, 0);
    n = 0;
    while (port_busy[0] && n < 20) begin tick(); n++; end
    check("R8 released A", int'(port_busy[0]), 0);
    check("R8 B still held", int'(port_busy[1]), 1);
    set_req(3, 0, 0, 0);
    for (int i = 0; i < 8; i++) tick();
    check("R8 A re-granted to waiter", int'(port_src[SW-1:0]), 2);
    set_req(2, 0, 1, 0);
    for (int i = 0; i < 8; i++) tick();
    set_req(2, 0, 0, 0);
    check("R8 A free again", int'(port_busy[0]), 0);

    // R4: processor 1 (entry 0, port A) names port id 1 -> no grant
    set_req(1, 1, 0, 1);
    seen = 0;
    for (int i = 0; i < 12; i++) begin tick(); if (hs_grant[1]) seen = 1; end
    check("R4 mismatched target no grant", int'(seen), 0);
    check("R4 A stays idle", int'(port_busy[0]), 0);

    // R6: correct target but FIFO A empty
    fifo_empty = 2'b01;
    set_req(1, 1, 0, 0);
    seen = 0;
    for (int i = 0; i < 12; i++) begin tick(); if (hs_grant[1]) seen = 1; end
    check("R6 grant offered", int'(seen), 1);
    check("R6 no link while empty", int'(port_busy[0]), 0);
    fifo_empty = 2'b00;
    for (int i = 0; i < 3; i++) tick();
    check("R6 link after data", int'(port_busy[0]), 1);
    check("R6 srcA", int'(port_src[SW-1:0]), 1);

    // random phase against the model
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < NP; p++) begin
        int r; r = int'($urandom_range(0, 99));
        set_req(p, r < 40, (r >= 40 && r < 52), int'($urandom_range(0, 2)));
      end
      fifo_empty = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      tick();
      if (hs_grant != '0 && $countones(hs_grant) != 1)
        check("R10 onehot grant", $countones(hs_grant), 1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule